// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM and takes charge of the command pins from reset until the device is ready. It runs the mandatory bring-up order in sequence. First it holds a quiet period with clock enable high, every byte mask high and only no-operation commands. Then it closes all banks, issues a programmable number of auto-refresh cycles, and loads the mode register. The moment the post-load settling time runs out it raises a ready flag.

After that the block becomes a periodic refresh scheduler. An interval timer counts the refresh period. Each expiry adds one to a small refresh debt. While the debt is non-zero and the row-cycle window since the last refresh has closed, a request goes to the memory arbiter. An acknowledge from the arbiter makes the block drive an auto-refresh on the following cycle and retire one unit of debt. Every delay is given in nanoseconds together with the clock period, and is turned into a whole number of cycles by rounding up.

Top module: `sdr_init_refresh`

## Requirements
- R1: From reset until the ready flag rises, `cke` is 1, every `dqm` bit is 1 and `cs_n` is 0. During the first PWR_CYC cycles after reset, `{ras_n,cas_n,we_n}` is 3'b111 (no-op).
- R2: Each delay in cycles equals ceil(ns*1000/T_CK_PS), with a floor of one cycle. For example, 65 ns at 10 ns gives 7 cycles and 15 ns gives 2.
- R3: In cycle PWR_CYC after reset the block issues precharge-all: `{ras_n,cas_n,we_n}` = 3'b010 with `a10` = 1. It is the only precharge during bring-up.
- R4: Exactly N_INIT_REF auto-refresh commands (3'b001) follow. The first comes RP_CYC cycles after the precharge and each later one comes RC_CYC cycles after the one before. Every cycle between commands is a no-op.
- R5: A mode-register load (3'b000) comes RC_CYC cycles after the last bring-up refresh. `mode_bits` carries MODE_VALUE in that cycle and is zero in every other cycle.
- R6: `init_done` rises exactly RSC_CYC cycles after the mode load, never earlier, and then stays high. In the same cycle `dqm` drops to all zeros.
- R7: After `init_done`, a refresh interval ends every REFI_CYC cycles. The first `ref_req` appears REFI_CYC cycles after `init_done` rises.
- R8: `ref_req` is never high before `init_done`. An `ref_ack` seen while `ref_req` is high produces an auto-refresh on the next cycle and retires one interval of debt. An `ref_ack` while `ref_req` is low has no effect on the command pins.
- R9: Two auto-refresh commands in normal operation are at least RC_CYC cycles apart, even when `ref_ack` is held high.
- R10: Refresh debt saturates at DEBT_MAX. After any number of unserved intervals, a held acknowledge yields at most DEBT_MAX refreshes before the next interval ends.
- R11: Synchronous reset returns the block to the R1 state, with `init_done` = 0 and `ref_req` = 0, and the whole bring-up runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Refresh wanted and allowed |
| init_done | output | 1 | Bring-up finished, device usable |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, all-bank select on precharge |
| mode_bits | output | MODE_W | Low address bits, mode value during the load |
| dqm | output | DQM_W | Byte masks |

## Verification
The bench places every bring-up command at its exact cycle, using delays that are not whole multiples of the clock. A design that truncated instead of rounding up would issue the first refresh or a later one a cycle early, and a late ready flag would show up one cycle off. The bench then lets five refresh intervals pass unserved and holds the acknowledge high. A design without a saturating debt would emit five refreshes instead of three, and one without the row-cycle lockout would pack them closer than seven cycles. A held acknowledge with no pending request must produce nothing, and a reset in normal operation must bring back the masked, no-op bring-up state.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REFA = 2'd2,
        CMD_MRS  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        PH_PWRUP = 3'd0,
        PH_PREA  = 3'd1,
        PH_REF   = 3'd2,
        PH_MRS   = 3'd3,
        PH_RUN   = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Pin levels for each command, chip selected
    function automatic pins_t encode(cmd_e c);
        pins_t p;
        p.cs_n = 1'b0;
        case (c)
            CMD_PREA: {p.ras_n, p.cas_n, p.we_n} = 3'b010;
            CMD_REFA: {p.ras_n, p.cas_n, p.we_n} = 3'b001;
            CMD_MRS:  {p.ras_n, p.cas_n, p.we_n} = 3'b000;
            default:  {p.ras_n, p.cas_n, p.we_n} = 3'b111;
        endcase
        return p;
    endfunction

    // Round a delay up to whole clock cycles, at least one
    function automatic int ns_to_cyc(int ns, int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
    import sdr_seq_pkg::*;
#(
    parameter int PWR_CYC = 50000,
    parameter int RP_CYC  = 2,
    parameter int RC_CYC  = 7,
    parameter int RSC_CYC = 2,
    parameter int N_REF   = 8
) (
    input  logic clk,
    input  logic rst,
    output cmd_e cmd,
    output logic done
);
    localparam int MAXC  = max2(max2(PWR_CYC, RP_CYC), max2(RC_CYC, RSC_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int REF_W = $clog2(N_REF + 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [REF_W-1:0]  left;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_PWRUP;
            cnt  <= CNT_W'(PWR_CYC - 1);
            left <= '0;
            cmd  <= CMD_NOP;
            done <= 1'b0;
        end else begin
            cmd <= CMD_NOP;
            case (ph)
                PH_PWRUP: begin
                    if (cnt_zero) begin
                        ph  <= PH_PREA;
                        cnt <= CNT_W'(RP_CYC - 1);
                        cmd <= CMD_PREA;
                    end else cnt <= cnt - CNT_W'(1);
                end
                PH_PREA: begin
                    if (cnt_zero) begin
                        ph   <= PH_REF;
                        cnt  <= CNT_W'(RC_CYC - 1);
                        left <= REF_W'(N_REF - 1);
                        cmd  <= CMD_REFA;
                    end else cnt <= cnt - CNT_W'(1);
                end
                PH_REF: begin
                    if (cnt_zero) begin
                        if (left != '0) begin
                            cnt  <= CNT_W'(RC_CYC - 1);
                            left <= left - REF_W'(1);
                            cmd  <= CMD_REFA;
                        end else begin
                            ph  <= PH_MRS;
                            cnt <= CNT_W'(RSC_CYC - 1);
                            cmd <= CMD_MRS;
                        end
                    end else cnt <= cnt - CNT_W'(1);
                end
                PH_MRS: begin
                    if (cnt_zero) begin
                        ph   <= PH_RUN;
                        done <= 1'b1;
                    end else cnt <= cnt - CNT_W'(1);
                end
                PH_RUN: ;
                default: ph <= PH_PWRUP;
            endcase
        end
    end

    // R6: ready never drops once raised
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R6: ready comes only out of the mode-load phase
    p_done_after_mrs_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ph) == PH_MRS);

    // R3: precharge-all only leaves the quiet period
    p_prea_from_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PREA) |-> ph == PH_PREA);

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
    import sdr_seq_pkg::*;
#(
    parameter int REFI_CYC = 1563,
    parameter int RC_CYC   = 7,
    parameter int DEBT_MAX = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic req,
    output logic refa
);
    localparam int TMR_W  = $clog2(REFI_CYC + 1);
    localparam int RC_W   = $clog2(RC_CYC + 1);
    localparam int DEBT_W = $clog2(DEBT_MAX + 1);

    logic [TMR_W-1:0]  tmr;
    logic [RC_W-1:0]   rc;
    logic [DEBT_W-1:0] debt;
    logic              tick;
    logic              grant;

    assign tick  = en && (tmr == '0);
    assign req   = en && (debt != '0) && (rc == '0);
    assign grant = req && ack;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tmr <= TMR_W'(REFI_CYC - 1);
        end else if (tmr == '0) begin
            tmr <= TMR_W'(REFI_CYC - 1);
        end else begin
            tmr <= tmr - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
            rc   <= '0;
            refa <= 1'b0;
        end else begin
            refa <= grant;
            if (tick && !grant) begin
                if (debt != DEBT_W'(DEBT_MAX)) debt <= debt + DEBT_W'(1);
            end else if (grant && !tick) begin
                debt <= debt - DEBT_W'(1);
            end
            if (grant)          rc <= RC_W'(RC_CYC - 1);
            else if (rc != '0)  rc <= rc - RC_W'(1);
        end
    end

    // R10: debt never passes its cap
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        debt <= DEBT_W'(DEBT_MAX));

    // R8: every refresh pulse traces back to a granted request
    p_refa_granted_r8: assert property (@(posedge clk) disable iff (rst)
        refa |-> $past(req && ack));

    // R9: no request right after a refresh
    p_rc_lockout_r9: assert property (@(posedge clk) disable iff (rst)
        refa |-> !req);

endmodule

// File: rtl/sdr_pin_drive.sv
module sdr_pin_drive
    import sdr_seq_pkg::*;
#(
    parameter int DQM_W      = 8,
    parameter int MODE_W     = 10,
    parameter int MODE_VALUE = 'h032
) (
    input  cmd_e              init_cmd,
    input  logic              refa,
    input  logic              done,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              a10,
    output logic [MODE_W-1:0] mode_bits,
    output logic [DQM_W-1:0]  dqm
);
    cmd_e  sel;
    pins_t p;

    always_comb begin
        if (done) sel = refa ? CMD_REFA : CMD_NOP;
        else      sel = init_cmd;
        p         = encode(sel);
        cs_n      = p.cs_n;
        ras_n     = p.ras_n;
        cas_n     = p.cas_n;
        we_n      = p.we_n;
        a10       = (sel == CMD_PREA);
        mode_bits = (sel == CMD_MRS) ? MODE_W'(MODE_VALUE) : '0;
        dqm       = done ? '0 : '1;
        cke       = 1'b1;
    end

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int T_CK_PS    = 10000,
    parameter int T_PWRUP_NS = 500000,
    parameter int T_RP_NS    = 20,
    parameter int T_RC_NS    = 70,
    parameter int T_RSC_NS   = 20,
    parameter int T_REFI_NS  = 15625,
    parameter int N_INIT_REF = 8,
    parameter int DEBT_MAX   = 7,
    parameter int DQM_W      = 8,
    parameter int MODE_W     = 10,
    parameter int MODE_VALUE = 'h032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic              init_done,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              a10,
    output logic [MODE_W-1:0] mode_bits,
    output logic [DQM_W-1:0]  dqm
);
    localparam int PWR_CYC  = ns_to_cyc(T_PWRUP_NS, T_CK_PS);
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS,    T_CK_PS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS,    T_CK_PS);
    localparam int RSC_CYC  = ns_to_cyc(T_RSC_NS,   T_CK_PS);
    localparam int REFI_CYC = ns_to_cyc(T_REFI_NS,  T_CK_PS);

    cmd_e init_cmd;
    logic refa;

    sdr_init_fsm #(
        .PWR_CYC(PWR_CYC), .RP_CYC(RP_CYC), .RC_CYC(RC_CYC),
        .RSC_CYC(RSC_CYC), .N_REF(N_INIT_REF)
    ) u_init (
        .clk(clk), .rst(rst), .cmd(init_cmd), .done(init_done)
    );

    sdr_refresh_sched #(
        .REFI_CYC(REFI_CYC), .RC_CYC(RC_CYC), .DEBT_MAX(DEBT_MAX)
    ) u_sched (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack),
        .req(ref_req), .refa(refa)
    );

    sdr_pin_drive #(
        .DQM_W(DQM_W), .MODE_W(MODE_W), .MODE_VALUE(MODE_VALUE)
    ) u_pins (
        .init_cmd(init_cmd), .refa(refa), .done(init_done),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .mode_bits(mode_bits), .dqm(dqm)
    );

    // R1: clock enable stays high throughout
    p_cke_high_r1: assert property (@(posedge clk) disable iff (rst)
        cke);

    // R1: masks stay high until ready
    p_dqm_masked_r1: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (dqm == '1));

    // R8: no refresh request during bring-up
    p_no_early_req_r8: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !ref_req);

    // R3: a precharge on the pins always selects all banks
    p_prea_all_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n) |-> a10);

    // R8: a refresh after ready only follows a request seen with an acknowledge
    p_run_refa_r8: assert property (@(posedge clk) disable iff (rst)
        (init_done && $past(init_done) && !ras_n && !cas_n && we_n)
        |-> $past(ref_req && ref_ack));

endmodule

// File: tb/sdr_init_refresh_tb.sv
module sdr_init_refresh_tb;

    localparam int DQM_W  = 8;
    localparam int MODE_W = 10;
    localparam int MODE_V = 'h032;
    // 300 ns -> 30, 15 ns -> 2, 65 ns -> 7, 20 ns -> 2, 1000 ns -> 100
    localparam int PWR  = 30;
    localparam int RP   = 2;
    localparam int RC   = 7;
    localparam int RSC  = 2;
    localparam int REFI = 100;
    localparam int NREF = 8;
    localparam int LOGN = 200;

    localparam int NVEC = 12;
    // period after reset release, expected {ras_n,cas_n,we_n}
    localparam int       VEC_P [NVEC] = '{0, 29, 30, 31, 32, 33, 38, 39, 81, 82, 88, 89};
    localparam bit [2:0] VEC_C [NVEC] = '{3'b111, 3'b111, 3'b010, 3'b111, 3'b001, 3'b111,
                                          3'b111, 3'b001, 3'b001, 3'b111, 3'b000, 3'b111};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_ack = 1'b0;
    logic ref_req, init_done, cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [MODE_W-1:0] mode_bits;
    logic [DQM_W-1:0]  dqm;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit [2:0]        cmd_log  [LOGN];
    bit              cs_log   [LOGN];
    bit              cke_log  [LOGN];
    bit              a10_log  [LOGN];
    bit              done_log [LOGN];
    bit              req_log  [LOGN];
    bit [DQM_W-1:0]  dqm_log  [LOGN];
    bit [MODE_W-1:0] mode_log [LOGN];

    always #4 clk = ~clk;

    sdr_init_refresh #(
        .T_CK_PS(10000), .T_PWRUP_NS(300), .T_RP_NS(15), .T_RC_NS(65),
        .T_RSC_NS(20), .T_REFI_NS(1000), .N_INIT_REF(NREF), .DEBT_MAX(3),
        .DQM_W(DQM_W), .MODE_W(MODE_W), .MODE_VALUE(MODE_V)
    ) u_dut (
        .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_req(ref_req),
        .init_done(init_done), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .mode_bits(mode_bits), .dqm(dqm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit [2:0] cmd_now();
        return {ras_n, cas_n, we_n};
    endfunction

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt_ref;
        int cnt_pre;
        int cnt_mrs;
        int bad;
        int first_req;
        int refs;
        int last;
        int min_gap;

        repeat (3) @(negedge clk);
        // R11/R1 reset state
        chk(cmd_now() == 3'b111 && !cs_n && cke, "R11", "reset command", int'(cmd_now()), 7);
        chk(dqm == '1 && !init_done && !ref_req, "R11", "reset dqm/done/req", int'(dqm), 255);
        rst = 1'b0;

        for (int k = 0; k < LOGN; k++) begin
            cmd_log[k]  = cmd_now();
            cs_log[k]   = cs_n;
            cke_log[k]  = cke;
            a10_log[k]  = a10;
            done_log[k] = init_done;
            req_log[k]  = ref_req;
            dqm_log[k]  = dqm;
            mode_log[k] = mode_bits;
            @(negedge clk);
        end

        // R2/R3/R4/R5: vector table of bring-up commands
        for (int v = 0; v < NVEC; v++) begin
            chk(cmd_log[VEC_P[v]] == VEC_C[v], "R4", $sformatf("cmd at period %0d", VEC_P[v]),
                int'(cmd_log[VEC_P[v]]), int'(VEC_C[v]));
        end

        // R1: quiet period and mask/enable levels during bring-up
        bad = 0;
        for (int k = 0; k < PWR; k++) if (cmd_log[k] != 3'b111) bad++;
        chk(bad == 0, "R1", "non-NOP in quiet period", bad, 0);
        bad = 0;
        for (int k = 0; k < 90; k++) if (dqm_log[k] != '1 || !cke_log[k] || cs_log[k]) bad++;
        chk(bad == 0, "R1", "mask/cke/cs during bring-up", bad, 0);

        // R3/R4/R5: command counts and spacing
        cnt_ref = 0; cnt_pre = 0; cnt_mrs = 0;
        for (int k = 0; k < 90; k++) begin
            if (cmd_log[k] == 3'b001) cnt_ref++;
            if (cmd_log[k] == 3'b010) cnt_pre++;
            if (cmd_log[k] == 3'b000) cnt_mrs++;
        end
        chk(cnt_pre == 1, "R3", "precharge count", cnt_pre, 1);
        chk(a10_log[PWR] == 1'b1, "R3", "a10 on precharge", int'(a10_log[PWR]), 1);
        chk(cnt_ref == NREF, "R4", "bring-up refresh count", cnt_ref, NREF);
        bad = 0;
        for (int i = 0; i < NREF; i++) if (cmd_log[PWR + RP + i * RC] != 3'b001) bad++;
        chk(bad == 0, "R2", "refresh slots (rounded delays)", bad, 0);
        chk(cnt_mrs == 1, "R5", "mode load count", cnt_mrs, 1);
        chk(mode_log[88] == MODE_W'(MODE_V), "R5", "mode bits on load", int'(mode_log[88]), MODE_V);
        chk(mode_log[87] == '0 && mode_log[89] == '0, "R5", "mode bits idle",
            int'(mode_log[87] | mode_log[89]), 0);

        // R6: ready timing and mask release
        chk(done_log[89] == 1'b0, "R6", "ready before settle", int'(done_log[89]), 0);
        chk(done_log[90] == 1'b1, "R6", "ready at settle", int'(done_log[90]), 1);
        chk(dqm_log[90] == '0, "R6", "dqm after ready", int'(dqm_log[90]), 0);
        bad = 0;
        for (int k = 90; k < LOGN; k++) if (!done_log[k]) bad++;
        chk(bad == 0, "R6", "ready stays high", bad, 0);

        // R7/R8: first request one interval after ready
        first_req = -1;
        for (int k = LOGN - 1; k >= 0; k--) if (req_log[k]) first_req = k;
        chk(first_req == 90 + REFI, "R7", "first request period", first_req, 90 + REFI);
        bad = 0;
        for (int k = 90; k < LOGN; k++) if (cmd_log[k] != 3'b111) bad++;
        chk(bad == 0, "R8", "no refresh without ack", bad, 0);

        // R8: handshake (now at period 200)
        ref_ack = 1'b1;
        @(negedge clk);
        chk(cmd_now() == 3'b001, "R8", "refresh after ack", int'(cmd_now()), 1);
        chk(!ref_req, "R8", "request retired", int'(ref_req), 0);
        ref_ack = 1'b0;
        @(negedge clk);
        chk(cmd_now() == 3'b111, "R8", "single refresh", int'(cmd_now()), 7);

        // R10/R9: five intervals unserved (period 202 -> 700), then hold ack
        repeat (498) @(negedge clk);
        chk(ref_req, "R7", "request pending", int'(ref_req), 1);
        ref_ack = 1'b1;
        refs = 0; last = -100; min_gap = 1000;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (cmd_now() == 3'b001) begin
                refs++;
                if (j - last < min_gap) min_gap = j - last;
                last = j;
            end
        end
        chk(refs == 3, "R10", "refreshes from saturated debt", refs, 3);
        chk(min_gap == RC, "R9", "refresh spacing", min_gap, RC);
        chk(!ref_req, "R8", "ack with no request ignored", int'(ref_req), 0);
        ref_ack = 1'b0;

        // R11: reset in normal operation restarts bring-up
        rst = 1'b1;
        @(negedge clk);
        chk(!init_done && !ref_req && dqm == '1 && cmd_now() == 3'b111, "R11",
            "reset from run", int'(init_done), 0);
        rst = 1'b0;
        repeat (89) @(negedge clk);
        chk(!init_done, "R11", "ready before settle after reset", int'(init_done), 0);
        @(negedge clk);
        chk(init_done, "R11", "ready after rerun", int'(init_done), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule